// File: doc/BRIEF.md
# Interleaved Shared Memory with In-Bank Atomics

This block is the memory side of a split-transaction shared bus. It accepts tagged requests and answers each one later with a response that carries the same tag. Besides plain reads and writes, it performs three read-modify-write operations inside the storage itself: test-and-set, exchange and fetch-and-add. Every request, of any kind, returns the word as it was before the request touched it.

Storage is split into word-interleaved banks. The low address bits pick the bank. Each bank has one request slot and its own occupancy timer. An atomic operation holds its bank twice as long as a plain access. It leaves the bank as one single-word write-through transaction, and the response is accompanied by a one-cycle invalidate strobe so that caches can drop their copies of that word. Responses from different banks may overtake each other. Within one bank they keep request order.

Top module: `ilv_atomic_mem`

## Requirements
- R1: While and right after reset, rsp_valid and inv_valid are low, req_ready is high, and every stored word reads as zero.
- R2: The bank is req_addr[2:0] and the word inside the bank is the remaining upper address bits; every address holds its own independent word.
- R3: A plain read or write holds its bank for 3 cycles. When the bank is idle and no other response competes, the response is valid for one cycle, 4 clock edges after the edge that accepted the request.
- R4: An atomic operation holds its bank for 6 cycles. Its response is valid 7 clock edges after the accepting edge, under the same conditions.
- R5: Test-and-set (op code 2) returns the old word and stores 1.
- R6: Exchange (op code 3) returns the old word and stores req_data.
- R7: Fetch-and-add (op code 4) returns the old word and stores the old word plus req_data, modulo 2^DATA_W.
- R8: Read (op code 0) returns the word and leaves it unchanged. Write (op code 1) returns the old word and stores req_data. Each response carries the tag of its request.
- R9: inv_valid is high for exactly the one cycle in which an atomic operation's response is presented, with inv_addr equal to that request's address. inv_valid is never high for a read or a write.
- R10: req_ready is low while the addressed bank's request slot is occupied. A request presented while req_ready is low is ignored and changes no stored word.
- R11: Responses from one bank leave in acceptance order. When several banks finish in the same cycle, the lowest-numbered bank responds first and the others wait, one response per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Slot of the addressed bank can take the request |
| req_op | input | 3 | 0 read, 1 write, 2 test-and-set, 3 exchange, 4 fetch-and-add |
| req_addr | input | ADDR_W | Word address; low bits pick the bank |
| req_data | input | DATA_W | Write data, exchange value or addend |
| req_tag | input | TAG_W | Requester tag echoed in the response |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_tag | output | TAG_W | Tag of the answered request |
| rsp_data | output | DATA_W | Word value before the request |
| inv_valid | output | 1 | Invalidate strobe for a completed atomic |
| inv_addr | output | ADDR_W | Word address to invalidate |

## Verification
On every cycle the bound checker confirms four things. Each bank's response rises exactly 3 or 6 cycles after that bank began the operation. A bank never begins a new operation while an earlier result is still unsent. At most one bank is granted the response port. The invalidate strobe never appears without a response. The data returned by each operation kind, the address-to-bank decoding, the refusal of a request into a full slot, and the ordering between two banks finishing together can only be shown by the bench's scenarios. The bench checks these against a word-by-word model of the whole memory.

// File: rtl/ilv_atomic_pkg.sv
`timescale 1ns/1ps
package ilv_atomic_pkg;
   typedef enum logic [2:0] {
      OP_RD   = 3'd0,
      OP_WR   = 3'd1,
      OP_TAS  = 3'd2,
      OP_XCHG = 3'd3,
      OP_FADD = 3'd4
   } mem_op_e;

   function automatic logic op_is_atomic(input logic [2:0] op);
      return (op == OP_TAS) || (op == OP_XCHG) || (op == OP_FADD);
   endfunction
endpackage

// File: rtl/ilv_amo_alu.sv
`timescale 1ns/1ps
// Next-value computation for one bank: plain store, set-to-one, swap, add.
module ilv_amo_alu
   import ilv_atomic_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic [2:0]        op,
   input  logic [DATA_W-1:0] old_val,
   input  logic [DATA_W-1:0] operand,
   output logic [DATA_W-1:0] new_val,
   output logic              wr_en
);
   always_comb begin
      new_val = old_val;
      wr_en   = 1'b0;
      case (op)
         OP_WR:   begin new_val = operand;           wr_en = 1'b1; end
         OP_TAS:  begin new_val = DATA_W'(1);        wr_en = 1'b1; end
         OP_XCHG: begin new_val = operand;           wr_en = 1'b1; end
         OP_FADD: begin new_val = old_val + operand; wr_en = 1'b1; end
         default: ;
      endcase
   end
endmodule

// File: rtl/ilv_bank.sv
`timescale 1ns/1ps
// One interleaved bank: a single request slot, an occupancy timer,
// word storage and a result register held until the port grants it.
module ilv_bank
   import ilv_atomic_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 16,
   parameter int TAG_W     = 4,
   parameter int IDX_W     = 5,
   parameter int PLAIN_LAT = 3,
   parameter int ATOM_LAT  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_we,
   input  logic [2:0]        in_op,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [DATA_W-1:0] in_data,
   input  logic [TAG_W-1:0]  in_tag,
   input  logic              gnt,
   output logic              slot_full,
   output logic              out_rdy,
   output logic [TAG_W-1:0]  out_tag,
   output logic [DATA_W-1:0] out_data,
   output logic              out_atom,
   output logic [ADDR_W-1:0] out_addr,
   output logic              start_o,
   output logic              start_atom_o
);
   localparam int DEPTH = 1 << IDX_W;
   localparam int CNT_W = $clog2(ATOM_LAT + 1);
   localparam logic [CNT_W-1:0] LAT_P = CNT_W'(PLAIN_LAT);
   localparam logic [CNT_W-1:0] LAT_A = CNT_W'(ATOM_LAT);

   logic [DATA_W-1:0] mem [DEPTH];

   logic              slot_v;
   logic [2:0]        slot_op;
   logic [ADDR_W-1:0] slot_addr;
   logic [DATA_W-1:0] slot_data;
   logic [TAG_W-1:0]  slot_tag;
   logic [CNT_W-1:0]  cnt;
   logic              done_v;

   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] old_val, new_val;
   logic              wr_en, start, atom;

   assign idx   = slot_addr[ADDR_W-1 -: IDX_W];
   assign old_val = mem[idx];
   assign atom  = op_is_atomic(slot_op);
   assign start = slot_v && (cnt == '0) && (!done_v || gnt);

   ilv_amo_alu #(.DATA_W(DATA_W)) u_alu (
      .op(slot_op), .old_val(old_val), .operand(slot_data),
      .new_val(new_val), .wr_en(wr_en)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_v    <= 1'b0;
         slot_op   <= '0;
         slot_addr <= '0;
         slot_data <= '0;
         slot_tag  <= '0;
         cnt       <= '0;
         done_v    <= 1'b0;
         out_tag   <= '0;
         out_data  <= '0;
         out_atom  <= 1'b0;
         out_addr  <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         if (in_we) begin
            slot_v    <= 1'b1;
            slot_op   <= in_op;
            slot_addr <= in_addr;
            slot_data <= in_data;
            slot_tag  <= in_tag;
         end else if (start) begin
            slot_v <= 1'b0;
         end
         if (start) begin
            cnt      <= atom ? LAT_A : LAT_P;
            done_v   <= 1'b1;
            out_tag  <= slot_tag;
            out_data <= old_val;
            out_atom <= atom;
            out_addr <= slot_addr;
            if (wr_en) mem[idx] <= new_val;
         end else begin
            if (cnt != '0) cnt <= cnt - 1'b1;
            if (gnt) done_v <= 1'b0;
         end
      end
   end

   assign slot_full    = slot_v;
   assign out_rdy      = done_v && (cnt == '0);
   assign start_o      = start;
   assign start_atom_o = start && atom;
endmodule

// File: rtl/ilv_rsp_arb.sv
`timescale 1ns/1ps
// Fixed-priority grant of the shared response port; bank 0 is highest.
module ilv_rsp_arb #(
   parameter int N = 8
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);
   logic [N-1:0] taken;
   assign taken[0] = req[0];
   assign gnt[0]   = req[0];
   for (genvar i = 1; i < N; i++) begin : g_chain
      assign gnt[i]   = req[i] && !taken[i-1];
      assign taken[i] = taken[i-1] || req[i];
   end
endmodule

// File: rtl/ilv_atomic_mem.sv
`timescale 1ns/1ps
module ilv_atomic_mem
   import ilv_atomic_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 16,
   parameter int TAG_W     = 4,
   parameter int BANK_BITS = 3,
   parameter int PLAIN_LAT = 3,
   parameter int ATOM_LAT  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [2:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   input  logic [TAG_W-1:0]  req_tag,
   output logic              rsp_valid,
   output logic [TAG_W-1:0]  rsp_tag,
   output logic [DATA_W-1:0] rsp_data,
   output logic              inv_valid,
   output logic [ADDR_W-1:0] inv_addr
);
   localparam int NB    = 1 << BANK_BITS;
   localparam int IDX_W = ADDR_W - BANK_BITS;

   if (BANK_BITS < 1 || IDX_W < 1) begin : g_bad_split
      $error("address too narrow for the bank count");
   end
   if (PLAIN_LAT < 1 || ATOM_LAT < PLAIN_LAT) begin : g_bad_lat
      $error("latencies must satisfy 1 <= plain <= atomic");
   end

   logic [BANK_BITS-1:0] bsel;
   logic [NB-1:0] slot_full, bank_rdy, bank_gnt, bank_start, bank_start_atom, bank_atom;
   logic [TAG_W-1:0]  b_tag  [NB];
   logic [DATA_W-1:0] b_data [NB];
   logic [ADDR_W-1:0] b_addr [NB];

   assign bsel      = req_addr[BANK_BITS-1:0];
   assign req_ready = !slot_full[bsel];

   for (genvar b = 0; b < NB; b++) begin : g_bank
      logic we;
      assign we = req_valid && req_ready && (bsel == BANK_BITS'(b));
      ilv_bank #(
         .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .IDX_W(IDX_W),
         .PLAIN_LAT(PLAIN_LAT), .ATOM_LAT(ATOM_LAT)
      ) u_bank (
         .clk(clk), .rst_n(rst_n), .in_we(we), .in_op(req_op),
         .in_addr(req_addr), .in_data(req_data), .in_tag(req_tag),
         .gnt(bank_gnt[b]), .slot_full(slot_full[b]), .out_rdy(bank_rdy[b]),
         .out_tag(b_tag[b]), .out_data(b_data[b]), .out_atom(bank_atom[b]),
         .out_addr(b_addr[b]), .start_o(bank_start[b]),
         .start_atom_o(bank_start_atom[b])
      );
   end

   ilv_rsp_arb #(.N(NB)) u_arb (.req(bank_rdy), .gnt(bank_gnt));

   logic sel_atom;
   always_comb begin
      rsp_tag  = '0;
      rsp_data = '0;
      inv_addr = '0;
      sel_atom = 1'b0;
      for (int b = 0; b < NB; b++) begin
         if (bank_gnt[b]) begin
            rsp_tag  = b_tag[b];
            rsp_data = b_data[b];
            inv_addr = b_addr[b];
            sel_atom = bank_atom[b];
         end
      end
   end

   assign rsp_valid = |bank_rdy;
   assign inv_valid = rsp_valid && sel_atom;
endmodule

// File: rtl/ilv_atomic_mem_chk.sv
`timescale 1ns/1ps
module ilv_atomic_mem_chk #(
   parameter int BANK_BITS = 3,
   parameter int PLAIN_LAT = 3,
   parameter int ATOM_LAT  = 6
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     rsp_valid,
   input logic                     inv_valid,
   input logic [(1<<BANK_BITS)-1:0] bank_rdy,
   input logic [(1<<BANK_BITS)-1:0] bank_gnt,
   input logic [(1<<BANK_BITS)-1:0] bank_start,
   input logic [(1<<BANK_BITS)-1:0] bank_start_atom
);
   localparam int NB    = 1 << BANK_BITS;
   localparam int AGE_W = $clog2(ATOM_LAT + 2);
   localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(ATOM_LAT + 1);

   // R9: an invalidate only travels with a response
   a_r9_inv_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid |-> rsp_valid);

   // R11: one bank at a time owns the response port
   a_r11_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_gnt));

   a_r11_grant_on_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ($countones(bank_gnt) == 1));

   for (genvar b = 0; b < NB; b++) begin : g_bank_chk
      logic [AGE_W-1:0] age, lim;
      logic             pend;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            age  <= '0;
            lim  <= '0;
            pend <= 1'b0;
         end else begin
            if (bank_start[b]) begin
               age  <= '0;
               lim  <= bank_start_atom[b] ? AGE_W'(ATOM_LAT) : AGE_W'(PLAIN_LAT);
               pend <= 1'b1;
            end else begin
               if (age != AGE_MAX) age <= age + 1'b1;
               if (bank_gnt[b]) pend <= 1'b0;
            end
         end
      end

      // R3 / R4: occupancy window of 3 or 6 cycles per operation
      a_r3_r4_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(bank_rdy[b]) |-> (pend && age == lim));

      // R11: in-bank order, no new operation before the earlier result leaves
      a_r11_serial_bank: assert property (@(posedge clk) disable iff (!rst_n)
         bank_start[b] |-> (!pend || bank_gnt[b]));
   end
endmodule

bind ilv_atomic_mem ilv_atomic_mem_chk #(
   .BANK_BITS(BANK_BITS), .PLAIN_LAT(PLAIN_LAT), .ATOM_LAT(ATOM_LAT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .inv_valid(inv_valid),
   .bank_rdy(bank_rdy), .bank_gnt(bank_gnt), .bank_start(bank_start),
   .bank_start_atom(bank_start_atom)
);

// File: tb/sim_ilv_atomic_mem.sv
`timescale 1ns/1ps
module sim_ilv_atomic_mem;
   localparam int NW = 256;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [2:0]  req_op = '0;
   logic [7:0]  req_addr = '0;
   logic [15:0] req_data = '0;
   logic [3:0]  req_tag = '0;
   logic        rsp_valid;
   logic [3:0]  rsp_tag;
   logic [15:0] rsp_data;
   logic        inv_valid;
   logic [7:0]  inv_addr;

   always #2 clk = ~clk;

   ilv_atomic_mem u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .req_tag(req_tag),
      .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
      .inv_valid(inv_valid), .inv_addr(inv_addr)
   );

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit done = 1'b0;
   logic [15:0] model [NW];

   // response log, written only here
   int          col_n = 0;
   logic [3:0]  col_tag [16];
   logic [15:0] col_data [16];
   logic        col_inv [16];
   int          col_cyc [16];

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rsp_valid) begin
         col_tag[col_n % 16]  <= rsp_tag;
         col_data[col_n % 16] <= rsp_data;
         col_inv[col_n % 16]  <= inv_valid;
         col_cyc[col_n % 16]  <= cyc;
         col_n <= col_n + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   function automatic bit is_atom(input logic [2:0] op);
      return op == 3'd2 || op == 3'd3 || op == 3'd4;
   endfunction

   // present a request and hold it until an edge accepts it
   task automatic issue(input logic [2:0] op, input logic [7:0] a, input logic [15:0] d, input logic [3:0] t);
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_addr = a; req_data = d; req_tag = t;
      #0.5;
      for (int w = 0; w < 100 && !req_ready; w++) begin
         @(negedge clk);
         #0.5;
      end
      @(posedge clk);
      #0.5;
      req_valid = 1'b0;
   endtask

   function automatic logic [15:0] next_val(input logic [2:0] op, input logic [15:0] o, input logic [15:0] d);
      case (op)
         3'd1: return d;
         3'd2: return 16'd1;
         3'd3: return d;
         3'd4: return o + d;
         default: return o;
      endcase
   endfunction

   // one isolated operation, checked against the model
   task automatic single(input logic [2:0] op, input logic [7:0] a, input logic [15:0] d, input logic [3:0] t, input string req);
      logic [15:0] old;
      int n;
      old = model[a];
      issue(op, a, d, t);
      n = 0;
      for (int w = 0; w < 20; w++) begin
         @(negedge clk);
         n++;
         if (rsp_valid) break;
      end
      if (is_atom(op)) chk(n == 8, "R4 atomic latency", n, 8);
      else             chk(n == 5, "R3 plain latency", n, 5);
      chk(rsp_data == old, req, rsp_data, old);
      chk(rsp_tag == t, "R8 tag echo", rsp_tag, t);
      chk(inv_valid == is_atom(op), "R9 invalidate presence", inv_valid, is_atom(op));
      if (is_atom(op)) chk(inv_addr == a, "R9 invalidate address", inv_addr, a);
      model[a] = next_val(op, old, d);
      @(negedge clk);
      chk(!rsp_valid && !inv_valid, "R9 one-cycle strobe", {rsp_valid, inv_valid}, 0);
   endtask

   initial begin
      wait (cyc >= 150000);
      chk(1'b0, "watchdog", cyc, 0);
      summary();
   end

   initial begin
      int base;
      for (int i = 0; i < NW; i++) model[i] = '0;
      repeat (4) @(negedge clk);
      chk(!rsp_valid && !inv_valid, "R1 outputs idle in reset", {rsp_valid, inv_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !rsp_valid && !inv_valid, "R1 idle after reset", {req_ready, rsp_valid, inv_valid}, 3'b100);

      // R1 / R8: everything reads zero
      for (int a = 0; a < NW; a++) single(3'd0, 8'(a), 16'h0, 4'(a), "R1 zero after reset");
      // R2 / R8: distinct value per address
      for (int a = 0; a < NW; a++) single(3'd1, 8'(a), 16'(a * 37 + 5), 4'(a), "R8 write returns old");
      for (int a = 0; a < NW; a++) single(3'd0, 8'(a), 16'h0, 4'(a), "R2 independent words");
      // R5, R6, R7 sweep
      for (int a = 0; a < NW; a++) begin
         case (a % 3)
            0: single(3'd2, 8'(a), 16'h0, 4'(a), "R5 test-and-set old word");
            1: single(3'd3, 8'(a), 16'(a) ^ 16'h5a5a, 4'(a), "R6 exchange old word");
            default: single(3'd4, 8'(a), 16'(a + 3), 4'(a), "R7 fetch-and-add old word");
         endcase
      end
      for (int a = 0; a < NW; a++) single(3'd0, 8'(a), 16'h0, 4'(a), "R5 R6 R7 stored result");

      // R7 wraparound, R5 repeated set
      single(3'd1, 8'd9, 16'hffff, 4'd1, "R8 write");
      single(3'd4, 8'd9, 16'd2, 4'd2, "R7 fetch-and-add before wrap");
      single(3'd0, 8'd9, 16'd0, 4'd3, "R7 wrapped sum");
      single(3'd2, 8'd12, 16'd0, 4'd4, "R5 first set");
      single(3'd2, 8'd12, 16'd0, 4'd5, "R5 second set sees 1");

      // R10 / R11: same-bank queue, refused request
      repeat (3) @(negedge clk);
      base = col_n;
      issue(3'd1, 8'h10, 16'h1111, 4'd1);
      issue(3'd1, 8'h18, 16'h2222, 4'd2);
      @(negedge clk);
      req_valid = 1'b1; req_op = 3'd1; req_addr = 8'h20; req_data = 16'hbeef; req_tag = 4'd3;
      #0.5;
      chk(!req_ready, "R10 ready low with full slot", req_ready, 0);
      @(posedge clk);
      #0.5;
      req_valid = 1'b0;
      repeat (25) @(negedge clk);
      chk(col_n - base == 2, "R10 refused request gives no response", col_n - base, 2);
      chk(col_tag[base % 16] == 4'd1, "R11 in-bank order first", col_tag[base % 16], 1);
      chk(col_tag[(base + 1) % 16] == 4'd2, "R11 in-bank order second", col_tag[(base + 1) % 16], 2);
      model[8'h10] = 16'h1111;
      model[8'h18] = 16'h2222;
      single(3'd0, 8'h20, 16'h0, 4'd7, "R10 refused write left word unchanged");
      single(3'd0, 8'h18, 16'h0, 4'd8, "R8 queued write stored");

      // R11: two banks finish together, bank 0 wins
      repeat (3) @(negedge clk);
      base = col_n;
      issue(3'd4, 8'h01, 16'd5, 4'd5);
      repeat (2) @(posedge clk);
      issue(3'd0, 8'h00, 16'd0, 4'd6);
      repeat (15) @(negedge clk);
      chk(col_n - base == 2, "R11 two responses", col_n - base, 2);
      chk(col_tag[base % 16] == 4'd6, "R11 lower bank first", col_tag[base % 16], 6);
      chk(col_tag[(base + 1) % 16] == 4'd5, "R11 higher bank waits", col_tag[(base + 1) % 16], 5);
      chk(col_cyc[(base + 1) % 16] == col_cyc[base % 16] + 1, "R11 back-to-back responses",
          col_cyc[(base + 1) % 16] - col_cyc[base % 16], 1);
      chk(col_data[(base + 1) % 16] == model[1], "R7 delayed atomic old word", col_data[(base + 1) % 16], model[1]);
      chk(col_inv[(base + 1) % 16] && !col_inv[base % 16], "R9 strobe follows the atomic",
          {col_inv[(base + 1) % 16], col_inv[base % 16]}, 2'b10);
      model[1] = model[1] + 16'd5;
      single(3'd0, 8'h01, 16'h0, 4'd9, "R7 delayed atomic stored");

      summary();
   end
endmodule